// File: doc/BRIEF.md
# Interleaved Cache-Line Fill Engine

This block answers a cache read miss by fetching one eight-word line from a set of low-order-interleaved memory banks and streaming the words to the cache. The word address of the line is split so that its lowest bits choose a bank and the remaining bits give the location inside that bank. Consecutive words of a line therefore live in different banks. Each bank keeps its own address register and its own data register, so all banks can work on the line at once. The banks' access times overlap, and the shared return bus then carries one word per cycle. The bank model is part of the block. It gives a cycle-accurate latency: 6 cycles for the first word a bank reads and 4 cycles for each later word from the same open row.

The control machine `fill_state_e` has four states. FS_IDLE moves to FS_ISSUE on an accepted request. FS_ISSUE hands a start address to one bank per cycle and moves to FS_STREAM after the last bank. FS_STREAM waits for word 7 to appear on the fill outputs and then moves to FS_DONE. FS_DONE lasts one cycle, pulses the completion flag and returns to FS_IDLE. Each bank runs its own small machine `bank_state_e`. BS_IDLE moves to BS_WAIT on a start. BS_WAIT counts down the latency and, when the count expires, either captures a word or moves to BS_PARK if its data register is still occupied. BS_PARK captures as soon as the register frees. After a capture the bank returns to BS_WAIT if it has words left to read and to BS_IDLE if it does not.

Top module: `ilv_line_fill`

## Requirements
- R1: While reset is asserted and directly after it, busy, fill_valid and fill_done are all 0.
- R2: A miss_req seen high in FS_IDLE is accepted at that clock edge. The line base is miss_addr with its three low bits cleared. busy reads 1 from that edge until the edge that leaves FS_DONE.
- R3: Word j of a line comes from word address base+j, which sits in bank (base+j) mod BANKS. Its data value is ((base+j) × 0x9E3779B1) mod 2^32.
- R4: Bank b receives its start address at edge 1+b after acceptance. Its first word is captured 6 edges later. Word 0 therefore appears on the fill outputs just after edge 8.
- R5: A bank captures its next word 4 edges after its previous capture, or at the edge where its data register is granted if that comes later.
- R6: Exactly one word moves per valid cycle. Words carry fill_idx 0 to 7 in ascending order, and a bank holds a ready word in its data register until that word's turn.
- R7: With BANKS=4, words 0 to 7 appear after edges 8 to 15 following acceptance, so the fill takes 15 cycles.
- R8: With BANKS=2, words 0 to 7 appear after edges 8, 9, 12, 13, 16, 17, 20 and 21 following acceptance.
- R9: fill_done is high for exactly one cycle, the cycle after word 7. busy falls in the cycle after that.
- R10: A miss_req raised while busy is 1, including the FS_DONE cycle, does not start a fill. It does not change the words being delivered, and every fill delivers exactly 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_req | input | 1 | Read-miss fill request |
| miss_addr | input | ADDR_W | Word address that missed |
| busy | output | 1 | A fill is in progress |
| fill_valid | output | 1 | fill_idx and fill_data carry a word this cycle |
| fill_idx | output | 3 | Position of the word within the line |
| fill_data | output | DATA_W | Returned word |
| fill_done | output | 1 | One-cycle line completion pulse |

## Verification
The bench computes every delivery time with a recurrence that uses only the 6-cycle and 4-cycle latencies and the one-word-per-cycle bus. It compares the design against that recurrence on every clock, for four banks and for two banks. A design that loads bank latencies from the wrong edge, or that reloads 6 instead of 4 for a bank's later words, moves the two-bank deliveries at words 2 and 4 and above. An unaligned address and the top line of the address space check that the base is masked and that the in-bank address carries upward. A stray request in the middle of a fill, and a request held high through the FS_DONE cycle, would show up as a restarted or corrupted line in a design that accepted requests while busy.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ISSUE,
        FS_STREAM,
        FS_DONE
    } fill_state_e;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_WAIT,
        BS_PARK
    } bank_state_e;

    // Multiplier that turns a word address into its stored value
    localparam logic [31:0] WORD_MIX = 32'h9E37_79B1;

endpackage

// File: rtl/lfe_bank.sv
module lfe_bank
    import lfe_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BANKS     = 4,
    parameter int BANK_ID   = 0,
    parameter int WORDS     = 2,
    parameter int FIRST_LAT = 6,
    parameter int NEXT_LAT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] line_base,
    input  logic              grant,
    output logic              dbr_full,
    output logic [DATA_W-1:0] dbr_data
);

    localparam int BANK_BITS = $clog2(BANKS);
    localparam int ABR_W     = ADDR_W - BANK_BITS;
    localparam int LAT_W     = $clog2(FIRST_LAT + 1);
    localparam int REM_W     = $clog2(WORDS + 1);
    localparam logic [BANK_BITS-1:0] ID_BITS = BANK_BITS'(BANK_ID);
    localparam logic [DATA_W-1:0]    MIX     = DATA_W'(WORD_MIX);

    bank_state_e       state, state_nx;
    logic [ABR_W-1:0]  abr;
    logic [LAT_W-1:0]  cnt;
    logic [REM_W-1:0]  rem;
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    logic expired, room, capture, more_left;

    always_comb begin
        expired   = ((state == BS_WAIT) && (cnt == LAT_W'(1))) || (state == BS_PARK);
        room      = !full_q || grant;
        capture   = expired && room;
        more_left = rem > REM_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BS_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            BS_IDLE:  if (start) state_nx = BS_WAIT;
            BS_WAIT: begin
                if (cnt == LAT_W'(1)) begin
                    if (capture) state_nx = more_left ? BS_WAIT : BS_IDLE;
                    else         state_nx = BS_PARK;
                end
            end
            BS_PARK:  if (capture) state_nx = more_left ? BS_WAIT : BS_IDLE;
            default:  state_nx = BS_IDLE;
        endcase
    end

    // Address buffer, latency counter and remaining-word count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abr <= '0;
            cnt <= '0;
            rem <= '0;
        end else if (start && (state == BS_IDLE)) begin
            abr <= ABR_W'((line_base + ADDR_W'(BANK_ID)) >> BANK_BITS);
            cnt <= LAT_W'(FIRST_LAT);
            rem <= REM_W'(WORDS);
        end else if (capture) begin
            abr <= abr + ABR_W'(1);
            cnt <= LAT_W'(NEXT_LAT);
            rem <= rem - REM_W'(1);
        end else if ((state == BS_WAIT) && (cnt != LAT_W'(1))) begin
            cnt <= cnt - LAT_W'(1);
        end
    end

    // Data buffer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (capture) begin
                full_q <= 1'b1;
                data_q <= DATA_W'({abr, ID_BITS}) * MIX;
            end else if (grant) begin
                full_q <= 1'b0;
            end
        end
    end

    always_comb begin
        dbr_full = full_q;
        dbr_data = data_q;
    end

    AST_DBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !grant) |=> (full_q && $stable(data_q))); // R6
    AST_GRANT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> full_q); // R6
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == BS_IDLE)); // R4
    AST_NEXT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && more_left) |=> (cnt == LAT_W'(NEXT_LAT))); // R5

endmodule

// File: rtl/lfe_return.sv
module lfe_return #(
    parameter int DATA_W     = 32,
    parameter int BANKS      = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [BANKS-1:0]  dbr_full,
    input  logic [DATA_W-1:0] dbr_data [BANKS],
    output logic [BANKS-1:0]  grant,
    output logic              fill_valid,
    output logic [$clog2(LINE_WORDS)-1:0] fill_idx,
    output logic [DATA_W-1:0] fill_data
);

    localparam int BANK_BITS = $clog2(BANKS);
    localparam int IDX_W     = $clog2(LINE_WORDS);
    localparam int CNT_W     = IDX_W + 1;

    logic [CNT_W-1:0]     nidx;
    logic [BANK_BITS-1:0] sel;
    logic                 more;

    always_comb begin
        sel  = nidx[BANK_BITS-1:0];
        more = nidx < CNT_W'(LINE_WORDS);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_grant
        assign grant[b] = more && dbr_full[b] && (sel == BANK_BITS'(b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nidx       <= '0;
            fill_valid <= 1'b0;
            fill_idx   <= '0;
            fill_data  <= '0;
        end else begin
            fill_valid <= |grant;
            if (clear) begin
                nidx <= '0;
            end else if (|grant) begin
                nidx      <= nidx + CNT_W'(1);
                fill_idx  <= nidx[IDX_W-1:0];
                fill_data <= dbr_data[sel];
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (!fill_valid || (fill_idx == $past(fill_idx) + IDX_W'(1)))); // R6

endmodule

// File: rtl/ilv_line_fill.sv
module ilv_line_fill
    import lfe_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int BANKS      = 4,
    parameter int LINE_WORDS = 8,
    parameter int FIRST_LAT  = 6,
    parameter int NEXT_LAT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              busy,
    output logic              fill_valid,
    output logic [2:0]        fill_idx,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_done
);

    localparam int BANK_BITS      = $clog2(BANKS);
    localparam int IDX_W          = $clog2(LINE_WORDS);
    localparam int WORDS_PER_BANK = LINE_WORDS / BANKS;
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_WORDS - 1);

    fill_state_e          state, state_nx;
    logic [ADDR_W-1:0]    line_base;
    logic [BANK_BITS-1:0] iss_cnt;
    logic                 accept;
    logic                 last_out;

    logic [BANKS-1:0]     start;
    logic [BANKS-1:0]     grant;
    logic [BANKS-1:0]     dbr_full;
    logic [DATA_W-1:0]    dbr_data [BANKS];
    logic [IDX_W-1:0]     idx_q;

    always_comb begin
        accept   = (state == FS_IDLE) && miss_req;
        last_out = fill_valid && (idx_q == IDX_W'(LINE_WORDS - 1));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE:   if (miss_req) state_nx = FS_ISSUE;
            FS_ISSUE:  if (iss_cnt == BANK_BITS'(BANKS - 1)) state_nx = FS_STREAM;
            FS_STREAM: if (last_out) state_nx = FS_DONE;
            FS_DONE:   state_nx = FS_IDLE;
            default:   state_nx = FS_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy      = (state != FS_IDLE);
        fill_done = (state == FS_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_base <= '0;
            iss_cnt   <= '0;
        end else if (accept) begin
            line_base <= miss_addr & ~LINE_MASK;
            iss_cnt   <= '0;
        end else if (state == FS_ISSUE) begin
            iss_cnt   <= iss_cnt + BANK_BITS'(1);
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign start[b] = (state == FS_ISSUE) && (iss_cnt == BANK_BITS'(b));

        lfe_bank #(
            .ADDR_W    (ADDR_W),
            .DATA_W    (DATA_W),
            .BANKS     (BANKS),
            .BANK_ID   (b),
            .WORDS     (WORDS_PER_BANK),
            .FIRST_LAT (FIRST_LAT),
            .NEXT_LAT  (NEXT_LAT)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start[b]),
            .line_base (line_base),
            .grant     (grant[b]),
            .dbr_full  (dbr_full[b]),
            .dbr_data  (dbr_data[b])
        );
    end

    lfe_return #(
        .DATA_W     (DATA_W),
        .BANKS      (BANKS),
        .LINE_WORDS (LINE_WORDS)
    ) u_return (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .dbr_full   (dbr_full),
        .dbr_data   (dbr_data),
        .grant      (grant),
        .fill_valid (fill_valid),
        .fill_idx   (idx_q),
        .fill_data  (fill_data)
    );

    always_comb fill_idx = 3'(idx_q);

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_done) |-> ($past(fill_valid) && ($past(idx_q) == IDX_W'(LINE_WORDS - 1)))); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (!fill_done && !busy)); // R9
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && miss_req) |=> $stable(line_base)); // R10
    AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_IDLE) |-> (grant == '0)); // R6

endmodule

// File: tb/sim_ilv_line_fill.sv
`timescale 1ns/1ps
module sim_ilv_line_fill;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req   = 1'b0;
    logic [15:0] addr  = 16'h0;

    logic        o_busy [2];
    logic        o_v    [2];
    logic [2:0]  o_idx  [2];
    logic [31:0] o_data [2];
    logic        o_done [2];

    ilv_line_fill #(.BANKS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .miss_req(req), .miss_addr(addr),
        .busy(o_busy[0]), .fill_valid(o_v[0]), .fill_idx(o_idx[0]),
        .fill_data(o_data[0]), .fill_done(o_done[0]));

    ilv_line_fill #(.BANKS(2)) u1 (
        .clk(clk), .rst_n(rst_n), .miss_req(req), .miss_addr(addr),
        .busy(o_busy[1]), .fill_valid(o_v[1]), .fill_idx(o_idx[1]),
        .fill_data(o_data[1]), .fill_done(o_done[1]));

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    int e0    [2] = '{-100, -100};
    int dn_e  [2] = '{-100, -100};
    logic [15:0] base [2];
    int obs   [2][8];
    int nval  [2];

    function automatic int nb_of(int m);
        return (m == 0) ? 4 : 2;
    endfunction

    // Delivery edge of word j counted from acceptance, from latencies 6/4 and one word per cycle
    function automatic int deliver_rel(int nb, int j);
        int ld [8];
        int dv [8];
        for (int k = 0; k <= j; k++) begin
            if (k < nb) ld[k] = 7 + k;
            else ld[k] = (ld[k-nb] + 4 > dv[k-nb]) ? ld[k-nb] + 4 : dv[k-nb];
            if (k == 0) dv[k] = ld[k] + 1;
            else dv[k] = (ld[k] + 1 > dv[k-1] + 1) ? ld[k] + 1 : dv[k-1] + 1;
        end
        return dv[j];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, edge_n);
        end
    endtask

    // Reference acceptance
    always @(posedge clk) begin
        edge_n = edge_n + 1;
        for (int m = 0; m < 2; m++) begin
            if (rst_n && req && (edge_n > dn_e[m] + 1)) begin
                e0[m]   = edge_n;
                base[m] = addr & 16'hFFF8;
                dn_e[m] = edge_n + deliver_rel(nb_of(m), 7) + 1;
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < 2; m++) begin
                bit   ev;
                int   ej;
                logic [31:0] ed;
                ev = 1'b0;
                ej = 0;
                for (int j = 0; j < 8; j++)
                    if (e0[m] + deliver_rel(nb_of(m), j) == edge_n) begin
                        ev = 1'b1;
                        ej = j;
                    end
                chk(o_v[m] == ev, (m == 0) ? "R7" : "R8", "fill_valid", o_v[m], ev);
                if (ev && o_v[m]) begin
                    ed = 32'(base[m] + 16'(ej)) * 32'h9E37_79B1;
                    chk(o_idx[m] == 3'(ej), "R6", "fill_idx", o_idx[m], ej);
                    chk(o_data[m] == ed, "R3", "fill_data", o_data[m], ed);
                end
                if (o_v[m]) begin
                    obs[m][o_idx[m]] = edge_n - e0[m];
                    nval[m]++;
                end
                chk(o_done[m] == (edge_n == dn_e[m]), "R9", "fill_done",
                    o_done[m], (edge_n == dn_e[m]));
                chk(o_busy[m] == (edge_n >= e0[m] && edge_n <= dn_e[m]), "R2", "busy",
                    o_busy[m], (edge_n >= e0[m] && edge_n <= dn_e[m]));
            end
        end
    end

    task automatic wait_idle();
        while ((edge_n <= dn_e[0] + 1) || (edge_n <= dn_e[1] + 1)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_obs();
        for (int m = 0; m < 2; m++) begin
            nval[m] = 0;
            for (int j = 0; j < 8; j++) obs[m][j] = -1;
        end
    endtask

    task automatic timing_checks();
        for (int j = 0; j < 8; j++) begin
            chk(obs[0][j] == 8 + j, (j == 0) ? "R4" : ((j == 4) ? "R5" : "R7"),
                "4-bank delivery edge", obs[0][j], 8 + j);
            chk(obs[1][j] == 8 + 4 * (j / 2) + (j % 2), (j == 0) ? "R4" : ((j == 2) ? "R5" : "R8"),
                "2-bank delivery edge", obs[1][j], 8 + 4 * (j / 2) + (j % 2));
        end
        chk(nval[0] == 8, "R10", "4-bank word count", nval[0], 8);
        chk(nval[1] == 8, "R10", "2-bank word count", nval[1], 8);
    endtask

    task automatic one_fill(input logic [15:0] a);
        clear_obs();
        @(negedge clk);
        req  = 1'b1;
        addr = a;
        @(negedge clk);
        req  = 1'b0;
        wait_idle();
        timing_checks();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired (edge %0d)", edge_n);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk(o_busy[m] == 1'b0, "R1", "busy in reset", o_busy[m], 0);
            chk(o_v[m] == 1'b0, "R1", "fill_valid in reset", o_v[m], 0);
            chk(o_done[m] == 1'b0, "R1", "fill_done in reset", o_done[m], 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++)
            chk(o_busy[m] == 1'b0, "R1", "busy after reset", o_busy[m], 0);

        one_fill(16'h0000);
        one_fill(16'h1235);   // unaligned: base 0x1230 (R2)
        one_fill(16'hFFFF);   // top line of the address space

        // Stray request in the middle of a fill must be ignored (R10)
        clear_obs();
        @(negedge clk);
        req  = 1'b1;
        addr = 16'h0840;
        @(negedge clk);
        req  = 1'b0;
        repeat (5) @(negedge clk);
        req  = 1'b1;
        addr = 16'h7770;
        @(negedge clk);
        req  = 1'b0;
        wait_idle();
        timing_checks();

        // Request held high: refused through FS_DONE, accepted back to back (R10)
        @(negedge clk);
        req  = 1'b1;
        addr = 16'h2468;
        repeat (60) @(negedge clk);
        req  = 1'b0;
        wait_idle();

        finish_run();
    end

endmodule